// File: doc/BRIEF.md
# Single-Wire Bus Master Timing Engine

This block turns one-shot commands from a clocked core into standard-speed waveforms on a single open-drain, single-wire serial bus. The core picks one of four operations: a bus reset with a check for a slave's answer, a slot that writes 0, a slot that writes 1, or a slot that reads one bit. The block then drives the line low through an output enable and samples the line through a synchroniser. The line is released for the time in between.

Every operation is built from two timed phases: a driven-low phase, then a released phase. The released phase contains the sample window and the recovery time. All durations are counted in microsecond ticks, taken from a parameter that gives the number of clock cycles per microsecond. A command raises `busy`. A one-cycle `done` closes the operation after its recovery time. The presence flag and the read bit hold their values until the next operation of their own kind.

Top module: `onewire_timing_engine`

## Requirements
- R1: Whenever `busy` is low, including right after reset, `ow_drive_low` is 0 and the line is released. After reset, `busy`, `done`, `presence` and `rd_bit` are 0.
- R2: Operation code 2'b00 (bus reset) drives the line low for RST_LOW_US (480 µs). It then releases the line for RST_HIGH_US (480 µs) before `done`, so `busy` lasts (RST_LOW_US+RST_HIGH_US)·CLKS_PER_US cycles.
- R3: At the end of a bus reset, `presence` is 1 if the synchronised line was seen low at any time in the window from PD_OPEN_US (60 µs) to PD_CLOSE_US (75 µs) after release. Otherwise it is 0. A slave answer that starts after the window leaves `presence` at 0.
- R4: Operation code 2'b01 (write 0) drives the line low for W0_LOW_US (60 µs). Operation code 2'b10 (write 1) drives it low for W1_LOW_US (6 µs). Each slot, with its recovery time, keeps `busy` high for (SLOT_US+REC_US)·CLKS_PER_US cycles.
- R5: Outside a bus reset, the line is never held low for more than 120 µs at a time.
- R6: Operation code 2'b11 (read) drives the line low for RD_LOW_US (2 µs). It then releases the line and latches the synchronised line level into `rd_bit` RD_SAMPLE_US (12 µs) after the falling edge. The read slot lasts as long as a write slot.
- R7: A `cmd_valid` that arrives while `busy` is high is ignored. It does not change the timing or result of the running operation and produces no extra `done`.
- R8: `done` is high for exactly one cycle per accepted command, in the first cycle in which `busy` is low again. At least REC_US of released line come before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_valid | input | 1 | Command strobe, taken only while idle |
| cmd_op | input | 2 | Operation: 00 reset, 01 write 0, 10 write 1, 11 read |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle end-of-operation pulse |
| presence | output | 1 | A slave answered the last bus reset |
| rd_bit | output | 1 | Bit sampled by the last read slot |
| ow_drive_low | output | 1 | Open-drain enable: 1 pulls the line low |
| ow_line_in | input | 1 | Level of the bus line, asynchronous |

## Verification
The presence window is the hardest corner to reach. It lasts only 15 µs, and a slave that answers late has to be told apart from one that answers inside the window. This needs a slave whose answer delay can be controlled. The bench models the bus as a wired-AND of the block's enable and a responder. The responder's delay after release is set per operation: 30 µs and 70 µs must give presence, 80 µs must not, and a silent bus must clear the flag. The same responder stretches read slots low when it returns a 0. A command strobed in the middle of a write slot checks that the slot's measured timing stays unchanged and that only one `done` appears.

// File: rtl/owt_pkg.sv
// Shared types of the single-wire timing engine.
// Assumes the two-bit operation encoding is fixed at the block's edge.
package owt_pkg;
    typedef enum logic [1:0] {
        OP_RESET = 2'b00,
        OP_WR0   = 2'b01,
        OP_WR1   = 2'b10,
        OP_READ  = 2'b11
    } owt_op_e;

    typedef enum logic [1:0] {
        PH_IDLE = 2'b00,
        PH_LOW  = 2'b01,
        PH_HIGH = 2'b10
    } owt_phase_e;
endpackage

// File: rtl/owt_sync.sv
// Multi-stage synchroniser for the asynchronous bus line level.
// Assumes the idle level is high, so every stage resets to 1.
module owt_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] chain_q;

    // Shift the raw level through the stage chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '1;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], async_in};
        end
    end

    assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/owt_tick.sv
// Microsecond prescaler: pulses tick on the last cycle of each microsecond.
// Assumes restart realigns the microsecond grid to the next cycle.
module owt_tick #(
    parameter int CLKS_PER_US = 125
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic tick
);
    localparam int CW = (CLKS_PER_US > 1) ? $clog2(CLKS_PER_US) : 1;
    localparam logic [CW-1:0] LAST = CW'(CLKS_PER_US - 1);

    logic [CW-1:0] cnt_q;

    assign tick = (cnt_q == LAST);

    // Count cycles within the current microsecond.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/owt_seq.sv
// Phase sequencer: each operation is a driven-low phase followed by a
// released phase that holds the sample window and the recovery time.
// Assumes tick marks microsecond ends aligned to each phase start.
module owt_seq
    import owt_pkg::*;
#(
    parameter int RST_LOW_US   = 480,
    parameter int RST_HIGH_US  = 480,
    parameter int PD_OPEN_US   = 60,
    parameter int PD_CLOSE_US  = 75,
    parameter int W0_LOW_US    = 60,
    parameter int W1_LOW_US    = 6,
    parameter int RD_LOW_US    = 2,
    parameter int RD_SAMPLE_US = 12,
    parameter int SLOT_US      = 65,
    parameter int REC_US       = 2
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    cmd_valid,
    input  owt_op_e cmd_op,
    input  logic    line_s,
    input  logic    tick,
    output logic    restart,
    output logic    drive_low,
    output logic    busy,
    output logic    done,
    output logic    presence,
    output logic    rd_bit,
    output owt_op_e op_cur
);
    localparam int MAX_US = (RST_LOW_US > RST_HIGH_US) ? RST_LOW_US : RST_HIGH_US;
    localparam int UW = $clog2(MAX_US + 1);
    localparam logic [UW-1:0] T_RST_LOW  = UW'(RST_LOW_US);
    localparam logic [UW-1:0] T_RST_HIGH = UW'(RST_HIGH_US);
    localparam logic [UW-1:0] T_W0_LOW   = UW'(W0_LOW_US);
    localparam logic [UW-1:0] T_W1_LOW   = UW'(W1_LOW_US);
    localparam logic [UW-1:0] T_RD_LOW   = UW'(RD_LOW_US);
    localparam logic [UW-1:0] T_W0_HIGH  = UW'(SLOT_US - W0_LOW_US + REC_US);
    localparam logic [UW-1:0] T_W1_HIGH  = UW'(SLOT_US - W1_LOW_US + REC_US);
    localparam logic [UW-1:0] T_RD_HIGH  = UW'(SLOT_US - RD_LOW_US + REC_US);
    localparam logic [UW-1:0] PD_OPEN    = UW'(PD_OPEN_US);
    localparam logic [UW-1:0] PD_CLOSE   = UW'(PD_CLOSE_US);
    localparam logic [UW-1:0] RD_AT      = UW'(RD_SAMPLE_US - RD_LOW_US - 1);

    owt_phase_e    state_q;
    owt_op_e       op_q;
    logic [UW-1:0] us_q;
    logic          seen_q;
    logic          presence_q;
    logic          rd_q;
    logic          done_q;

    logic [UW-1:0] low_target;
    logic [UW-1:0] high_target;
    logic [UW-1:0] target;
    logic          accept;
    logic          phase_end;
    logic          in_window_low;

    // Pick phase lengths for the running operation.
    always_comb begin
        unique case (op_q)
            OP_RESET: begin low_target = T_RST_LOW; high_target = T_RST_HIGH; end
            OP_WR0:   begin low_target = T_W0_LOW;  high_target = T_W0_HIGH;  end
            OP_WR1:   begin low_target = T_W1_LOW;  high_target = T_W1_HIGH;  end
            default:  begin low_target = T_RD_LOW;  high_target = T_RD_HIGH;  end
        endcase
    end

    // Decode acceptance, phase end and the presence window.
    always_comb begin
        target        = (state_q == PH_LOW) ? low_target : high_target;
        accept        = cmd_valid && (state_q == PH_IDLE);
        phase_end     = (state_q != PH_IDLE) && tick && (us_q == target - 1'b1);
        restart       = accept || phase_end;
        in_window_low = (state_q == PH_HIGH) && (op_q == OP_RESET) &&
                        (us_q >= PD_OPEN) && (us_q < PD_CLOSE) && !line_s;
    end

    // Advance phases and the microsecond counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PH_IDLE;
            op_q    <= OP_RESET;
            us_q    <= '0;
        end else if (accept) begin
            state_q <= PH_LOW;
            op_q    <= cmd_op;
            us_q    <= '0;
        end else if (phase_end) begin
            state_q <= (state_q == PH_LOW) ? PH_HIGH : PH_IDLE;
            us_q    <= '0;
        end else if (tick && state_q != PH_IDLE) begin
            us_q <= us_q + 1'b1;
        end
    end

    // Record presence evidence and publish it at the end of a reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_q     <= 1'b0;
            presence_q <= 1'b0;
        end else if (accept) begin
            seen_q <= 1'b0;
        end else if (state_q == PH_HIGH && op_q == OP_RESET) begin
            seen_q <= seen_q || in_window_low;
            if (phase_end) begin
                presence_q <= seen_q || in_window_low;
            end
        end
    end

    // Latch the read bit at the sample instant of a read slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q <= 1'b0;
        end else if (state_q == PH_HIGH && op_q == OP_READ && tick && us_q == RD_AT) begin
            rd_q <= line_s;
        end
    end

    // Pulse done as the released phase closes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
        end else begin
            done_q <= (state_q == PH_HIGH) && phase_end;
        end
    end

    assign drive_low = (state_q == PH_LOW);
    assign busy      = (state_q != PH_IDLE);
    assign done      = done_q;
    assign presence  = presence_q;
    assign rd_bit    = rd_q;
    assign op_cur    = op_q;

    a_r7_busy_ignore: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cmd_valid) |=> $stable(op_q));
    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r8_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
endmodule

// File: rtl/onewire_timing_engine.sv
// Top of the single-wire bus master timing engine: synchroniser,
// microsecond prescaler and phase sequencer, plus line-timing checks.
// Assumes an external pull-up holds the line high when released.
module onewire_timing_engine
    import owt_pkg::*;
#(
    parameter int CLKS_PER_US  = 125,
    parameter int SYNC_STAGES  = 2,
    parameter int RST_LOW_US   = 480,
    parameter int RST_HIGH_US  = 480,
    parameter int PD_OPEN_US   = 60,
    parameter int PD_CLOSE_US  = 75,
    parameter int W0_LOW_US    = 60,
    parameter int W1_LOW_US    = 6,
    parameter int RD_LOW_US    = 2,
    parameter int RD_SAMPLE_US = 12,
    parameter int SLOT_US      = 65,
    parameter int REC_US       = 2,
    parameter int MAX_LOW_US   = 120
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_valid,
    input  logic [1:0] cmd_op,
    output logic       busy,
    output logic       done,
    output logic       presence,
    output logic       rd_bit,
    output logic       ow_drive_low,
    input  logic       ow_line_in
);
    logic    line_s;
    logic    tick;
    logic    restart;
    owt_op_e op_cur;

    owt_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (ow_line_in),
        .sync_out (line_s)
    );

    owt_tick #(.CLKS_PER_US(CLKS_PER_US)) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .tick    (tick)
    );

    owt_seq #(
        .RST_LOW_US   (RST_LOW_US),
        .RST_HIGH_US  (RST_HIGH_US),
        .PD_OPEN_US   (PD_OPEN_US),
        .PD_CLOSE_US  (PD_CLOSE_US),
        .W0_LOW_US    (W0_LOW_US),
        .W1_LOW_US    (W1_LOW_US),
        .RD_LOW_US    (RD_LOW_US),
        .RD_SAMPLE_US (RD_SAMPLE_US),
        .SLOT_US      (SLOT_US),
        .REC_US       (REC_US)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_op    (owt_op_e'(cmd_op)),
        .line_s    (line_s),
        .tick      (tick),
        .restart   (restart),
        .drive_low (ow_drive_low),
        .busy      (busy),
        .done      (done),
        .presence  (presence),
        .rd_bit    (rd_bit),
        .op_cur    (op_cur)
    );

    // Checker state: lengths of the current low and released stretches.
    logic [31:0] low_run_q;
    logic [31:0] rel_run_q;

    // Measure consecutive driven and released cycles, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_run_q <= '0;
            rel_run_q <= '0;
        end else if (ow_drive_low) begin
            low_run_q <= (low_run_q == '1) ? low_run_q : low_run_q + 1'b1;
            rel_run_q <= '0;
        end else begin
            low_run_q <= '0;
            rel_run_q <= (rel_run_q == '1) ? rel_run_q : rel_run_q + 1'b1;
        end
    end

    a_r1_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !ow_drive_low);
    a_r5_slot_low_limit: assert property (@(posedge clk) disable iff (!rst_n)
        (ow_drive_low && op_cur != OP_RESET) |-> (low_run_q < 32'(MAX_LOW_US * CLKS_PER_US)));
    a_r2_reset_low_min: assert property (@(posedge clk) disable iff (!rst_n)
        (!ow_drive_low && low_run_q != 0 && op_cur == OP_RESET)
            |-> (low_run_q >= 32'(RST_LOW_US * CLKS_PER_US)));
    a_r2_reset_high_min: assert property (@(posedge clk) disable iff (!rst_n)
        (done && op_cur == OP_RESET) |-> (rel_run_q >= 32'(RST_HIGH_US * CLKS_PER_US)));
    a_r8_recovery_min: assert property (@(posedge clk) disable iff (!rst_n)
        (done && op_cur != OP_RESET) |-> (rel_run_q >= 32'(REC_US * CLKS_PER_US)));
endmodule

// File: tb/test_onewire_timing_engine.sv
// Scoreboard bench: the driver queues expected results, the monitor
// measures each operation at the ports and compares on done.
module test_onewire_timing_engine;
    localparam int CPU = 4;
    localparam int RST_CYC  = 480 * CPU;
    localparam int SLOT_CYC = (65 + 2) * CPU;

    typedef struct {
        logic [1:0] op;
        int         exp_low;
        int         exp_busy;
        logic       chk_pres;
        logic       exp_pres;
        logic       chk_rd;
        logic       exp_rd;
        string      tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [1:0] cmd_op = 2'b00;
    logic       busy, done, presence, rd_bit, ow_drive_low;
    logic       slave_low = 1'b0;
    logic       ow_line_in;

    int checks = 0;
    int fails = 0;
    exp_t sb[$];

    // Responder configuration.
    logic sl_present = 1'b0;
    int   sl_delay_us = 30;
    logic sl_read_zero = 1'b0;

    always #4 clk = ~clk;

    assign ow_line_in = !(ow_drive_low || slave_low);

    onewire_timing_engine #(.CLKS_PER_US(CPU)) i_onewire_timing_engine (
        .clk          (clk),
        .rst_n        (rst_n),
        .cmd_valid    (cmd_valid),
        .cmd_op       (cmd_op),
        .busy         (busy),
        .done         (done),
        .presence     (presence),
        .rd_bit       (rd_bit),
        .ow_drive_low (ow_drive_low),
        .ow_line_in   (ow_line_in)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Slave model: presence answer after a long low, zero-bit stretch on reads.
    int  m_low = 0;
    logic m_prev = 1'b0;
    int  pd_wait = -1;
    int  hold = 0;
    always @(posedge clk) begin
        if (ow_drive_low) m_low <= m_low + 1;
        else m_low <= 0;
        m_prev <= ow_drive_low;
        if (m_prev && !ow_drive_low && m_low >= 400 * CPU && sl_present)
            pd_wait <= sl_delay_us * CPU;
        else if (pd_wait > 0)
            pd_wait <= pd_wait - 1;
        else if (pd_wait == 0) begin
            pd_wait <= -1;
            hold <= 120 * CPU;
        end
        if (!m_prev && ow_drive_low && sl_read_zero)
            hold <= 30 * CPU;
        else if (hold > 0 && !(pd_wait == 0))
            hold <= hold - 1;
    end
    always_comb slave_low = (hold > 0);

    // Monitor: measure widths per operation and score on done.
    int low_w = 0;
    int busy_w = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (done) begin
                if (sb.size() == 0) begin
                    check(1'b0, "R7 unexpected done", 1, 0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    check(low_w == e.exp_low, {e.tag, " low width"}, low_w, e.exp_low);
                    check(busy_w == e.exp_busy, {e.tag, " busy length"}, busy_w, e.exp_busy);
                    check(!ow_drive_low && !busy, "R8 done ends busy, R1 released", int'(busy), 0);
                    if (e.chk_pres) check(presence == e.exp_pres, {e.tag, " presence"}, int'(presence), int'(e.exp_pres));
                    if (e.chk_rd) check(rd_bit == e.exp_rd, {e.tag, " read bit"}, int'(rd_bit), int'(e.exp_rd));
                end
                low_w = 0;
                busy_w = 0;
            end else begin
                if (ow_drive_low) low_w++;
                if (busy) busy_w++;
            end
        end
    end

    task automatic run_op(input logic [1:0] op, input logic chk_pres, input logic exp_pres,
                          input logic chk_rd, input logic exp_rd, input string tag,
                          input bit poke_busy);
        exp_t e;
        e.op = op; e.chk_pres = chk_pres; e.exp_pres = exp_pres;
        e.chk_rd = chk_rd; e.exp_rd = exp_rd; e.tag = tag;
        case (op)
            2'b00: begin e.exp_low = RST_CYC;   e.exp_busy = 2 * RST_CYC; end
            2'b01: begin e.exp_low = 60 * CPU;  e.exp_busy = SLOT_CYC; end
            2'b10: begin e.exp_low = 6 * CPU;   e.exp_busy = SLOT_CYC; end
            default: begin e.exp_low = 2 * CPU; e.exp_busy = SLOT_CYC; end
        endcase
        sb.push_back(e);
        @(negedge clk);
        cmd_op = op;
        cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        if (poke_busy) begin
            repeat (20) @(negedge clk);
            cmd_op = 2'b00;
            cmd_valid = 1'b1;
            @(negedge clk);
            cmd_valid = 1'b0;
        end
        while (!done) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    // Stimulus sequence.
    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !done && !presence && !rd_bit && !ow_drive_low,
              "R1 reset state", int'({busy, done, presence, rd_bit, ow_drive_low}), 0);
        sl_present = 1'b1; sl_delay_us = 30;
        run_op(2'b00, 1'b1, 1'b1, 1'b0, 1'b0, "R2 R3 reset early answer", 1'b0);
        sl_present = 1'b0;
        run_op(2'b00, 1'b1, 1'b0, 1'b0, 1'b0, "R3 reset silent bus", 1'b0);
        sl_present = 1'b1; sl_delay_us = 70;
        run_op(2'b00, 1'b1, 1'b1, 1'b0, 1'b0, "R3 answer inside window", 1'b0);
        sl_delay_us = 80;
        run_op(2'b00, 1'b1, 1'b0, 1'b0, 1'b0, "R3 answer after window", 1'b0);
        sl_present = 1'b0;
        run_op(2'b01, 1'b0, 1'b0, 1'b0, 1'b0, "R4 R5 write 0", 1'b0);
        run_op(2'b10, 1'b0, 1'b0, 1'b0, 1'b0, "R4 write 1", 1'b0);
        sl_read_zero = 1'b1;
        run_op(2'b11, 1'b0, 1'b0, 1'b1, 1'b0, "R6 read zero", 1'b0);
        sl_read_zero = 1'b0;
        run_op(2'b11, 1'b0, 1'b0, 1'b1, 1'b1, "R6 read one", 1'b0);
        run_op(2'b01, 1'b0, 1'b0, 1'b0, 1'b0, "R7 write 0 with busy command", 1'b1);
        repeat (200) @(negedge clk);
        check(!busy && !ow_drive_low, "R7 ignored command started nothing", int'(busy), 0);
        check(sb.size() == 0, "R8 every operation completed", sb.size(), 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    // Watchdog.
    int wd = 0;
    always @(posedge clk) begin
        wd <= wd + 1;
        if (wd == 150000) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", wd, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule